// File: doc/BRIEF.md
# Pixel Byte Expander Port

This block gives a processor a view of a word-organised frame RAM in which every 4-bit pixel has its own byte address. The RAM packs four pixels into each 16-bit word. On the expander bus, each pixel sits in the low nibble of a byte, and two such bytes form one 16-bit bus word. The low bit of the expander word offset selects which byte of the backing word is used. The remaining bits, shifted down by one, give the word address inside the selected bank half.

On a read, the block issues a request to the RAM and returns the two pixels one cycle later with a valid strobe. On a write, it folds the low nibbles of the two bus bytes into one backing byte. It then places that byte in the correct lane and hands it to an external merge unit, always with priority merging requested. A bank-select input chooses which half of the RAM the expander sees.

Top module: `pix_expander`

## Requirements
- R1: The memory word address is the bank base plus `bus_ofs` shifted right by one. With `bank_sel`=1 the base is word 0. With `bank_sel`=0 the base is word 0x10000, so bit 16 of `mem_addr` is set.
- R2: For a read at an odd offset, `rd_data[11:8]` carries backing bits [7:4] and `rd_data[3:0]` carries backing bits [3:0].
- R3: For a read at an even offset, `rd_data[11:8]` carries backing bits [15:12] and `rd_data[3:0]` carries backing bits [11:8].
- R4: `rd_data` bits [15:12] and [7:4] are always zero, and all of `rd_data` is zero while `rd_valid` is low.
- R5: `rd_valid` is high for exactly the one cycle after each cycle that holds a read request, and never follows a write.
- R6: A write packs `bus_wdata[11:8]` as the upper nibble and `bus_wdata[3:0]` as the lower nibble of one byte. The upper nibble enable comes from `bus_be[1]` and the lower from `bus_be[0]`.
- R7: At an even offset, the packed byte goes to `mem_wdata[15:8]` with nibble enables in `mem_nib_en[3:2]`. At an odd offset it goes to `mem_wdata[7:0]` with enables in `mem_nib_en[1:0]`. The unused lane is zero in both data and enables.
- R8: Every write request leaves the block with `mem_prio`=1.
- R9: A write with `bus_be`=00 raises no `mem_req`.
- R10: Reset clears `rd_valid` and drops any read still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Expander access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 17 | Expander word offset |
| bus_be | input | 2 | Byte enables of the expander word |
| bus_wdata | input | 16 | Expander write data, pixels in low nibbles |
| bank_sel | input | 1 | 1 = lower bank half, 0 = upper bank half |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Two pixels, each in a byte's low nibble |
| mem_req | output | 1 | RAM / merge unit request |
| mem_we | output | 1 | Request is a write |
| mem_prio | output | 1 | Apply priority merge to this write |
| mem_addr | output | 17 | Backing word address |
| mem_wdata | output | 16 | Packed write word |
| mem_nib_en | output | 4 | Per-nibble write enables |
| mem_rdata | input | 16 | Backing word, one cycle after a read request |

## Verification
The only internal state is the pending-read flag and its lane bit. A wrong lane bit shows as swapped pixels in `rd_data` on the very cycle `rd_valid` rises. A stuck or stale pending flag shows as a missing, doubled or spurious `rd_valid` one cycle after the faulty request. Lane and address faults on the write path show up combinationally on the `mem_*` outputs in the same cycle as the request.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int WORD_W = 16;
    localparam int NIB_W  = 4;

    // which byte of the backing word an expander word maps to
    typedef enum logic {
        LANE_LO = 1'b0,   // odd offset  -> bits [7:0]
        LANE_HI = 1'b1    // even offset -> bits [15:8]
    } lane_e;

    typedef struct packed {
        logic [7:0] data;
        logic [1:0] nib_en;
    } packed_px_t;

    function automatic lane_e lane_of(input logic ofs_lsb);
        return ofs_lsb ? LANE_LO : LANE_HI;
    endfunction

    // fold the low nibbles of both bus bytes into one backing byte
    function automatic packed_px_t fold_pixels(input logic [WORD_W-1:0] w,
                                               input logic [1:0] be);
        packed_px_t p;
        p.data   = {w[11:8], w[3:0]};
        p.nib_en = be;
        return p;
    endfunction

    // spread one backing byte into two bus bytes
    function automatic logic [WORD_W-1:0] spread_pixels(input logic [7:0] b);
        return {4'h0, b[7:4], 4'h0, b[3:0]};
    endfunction

endpackage

// File: rtl/pix_addr_map.sv
module pix_addr_map #(
    parameter int BANK_LG2 = 16,
    localparam int AW = BANK_LG2 + 1
) (
    input  logic          bank_sel,
    input  logic [AW-1:0] ofs,
    output logic [AW-1:0] word_addr,
    output pix_pkg::lane_e lane
);
    // bank_sel=1 -> base 0 ; bank_sel=0 -> base 2**BANK_LG2
    assign word_addr = {~bank_sel, ofs[AW-1:1]};
    assign lane      = pix_pkg::lane_of(ofs[0]);
endmodule

// File: rtl/pix_wr_pack.sv
module pix_wr_pack (
    input  logic [pix_pkg::WORD_W-1:0] wdata,
    input  logic [1:0]                 be,
    input  pix_pkg::lane_e             lane,
    output logic [pix_pkg::WORD_W-1:0] lane_data,
    output logic [3:0]                 lane_nib_en,
    output logic                       any_en
);
    import pix_pkg::*;

    packed_px_t px;
    assign px     = fold_pixels(wdata, be);
    assign any_en = |px.nib_en;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic hit;
        assign hit = (lane == lane_e'(l));
        assign lane_data[l*8 +: 8]   = hit ? px.data   : 8'h00;
        assign lane_nib_en[l*2 +: 2] = hit ? px.nib_en : 2'b00;
    end
endmodule

// File: rtl/pix_rd_unpack.sv
module pix_rd_unpack (
    input  logic [pix_pkg::WORD_W-1:0] word,
    input  pix_pkg::lane_e             lane,
    input  logic                       valid,
    output logic [pix_pkg::WORD_W-1:0] pixels
);
    import pix_pkg::*;

    logic [7:0] sel_byte;
    always_comb begin
        sel_byte = (lane == LANE_HI) ? word[15:8] : word[7:0];
        pixels   = valid ? spread_pixels(sel_byte) : '0;
    end
endmodule

// File: rtl/pix_expander.sv
module pix_expander #(
    parameter int BANK_LG2 = 16,
    localparam int AW = BANK_LG2 + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_ofs,
    input  logic [1:0]    bus_be,
    input  logic [15:0]   bus_wdata,
    input  logic          bank_sel,
    output logic          rd_valid,
    output logic [15:0]   rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_prio,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic [3:0]    mem_nib_en,
    input  logic [15:0]   mem_rdata
);
    import pix_pkg::*;

    lane_e      req_lane;
    lane_e      pend_lane;
    logic       pend_rd;
    logic       wr_any;
    logic [3:0] wr_nib;

    pix_addr_map #(.BANK_LG2(BANK_LG2)) u_map (
        .bank_sel  (bank_sel),
        .ofs       (bus_ofs),
        .word_addr (mem_addr),
        .lane      (req_lane)
    );

    pix_wr_pack u_pack (
        .wdata       (bus_wdata),
        .be          (bus_be),
        .lane        (req_lane),
        .lane_data   (mem_wdata),
        .lane_nib_en (wr_nib),
        .any_en      (wr_any)
    );

    // reads always go out; writes only when some nibble is enabled
    assign mem_req    = bus_req & (~bus_we | wr_any);
    assign mem_we     = bus_req & bus_we;
    assign mem_prio   = bus_req & bus_we & wr_any;
    assign mem_nib_en = bus_we ? wr_nib : 4'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_rd   <= 1'b0;
            pend_lane <= LANE_LO;
        end else begin
            pend_rd   <= bus_req & ~bus_we;
            pend_lane <= req_lane;
        end
    end

    assign rd_valid = pend_rd;

    pix_rd_unpack u_unpack (
        .word   (mem_rdata),
        .lane   (pend_lane),
        .valid  (pend_rd),
        .pixels (rd_data)
    );
endmodule

// File: rtl/pix_expander_chk.sv
module pix_expander_chk #(
    parameter int BANK_LG2 = 16,
    localparam int AW = BANK_LG2 + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_ofs,
    input logic [1:0]    bus_be,
    input logic          bank_sel,
    input logic          rd_valid,
    input logic [15:0]   rd_data,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_prio,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_wdata,
    input logic [3:0]    mem_nib_en,
    input logic [15:0]   mem_rdata
);
    AST_BANK_BASE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[AW-1] == ~bank_sel) && (mem_addr[AW-2:0] == bus_ofs[AW-1:1])); // R1

    AST_RD_ODD_MAP: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(bus_ofs[0])) |-> (rd_data[11:8] == mem_rdata[7:4] && rd_data[3:0] == mem_rdata[3:0])); // R2

    AST_RD_EVEN_MAP: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !$past(bus_ofs[0])) |-> (rd_data[11:8] == mem_rdata[15:12] && rd_data[3:0] == mem_rdata[11:8])); // R3

    AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15:12] == 4'h0) && (rd_data[7:4] == 4'h0) && (rd_valid || rd_data == 16'h0)); // R4

    AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> rd_valid); // R5

    AST_NO_WR_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> !rd_valid); // R5

    AST_WR_LANE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (bus_ofs[0] ? (mem_nib_en[3:2] == 2'b00 && mem_wdata[15:8] == 8'h00)
                                            : (mem_nib_en[1:0] == 2'b00 && mem_wdata[7:0] == 8'h00))); // R7

    AST_WR_PRIO: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_prio); // R8

    AST_ZERO_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_be == 2'b00) |-> !mem_req); // R9

    AST_ONE_HOT_NIB: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($countones(mem_nib_en) == $countones(bus_be))); // R6
endmodule

bind pix_expander pix_expander_chk #(.BANK_LG2(BANK_LG2)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_ofs    (bus_ofs),
    .bus_be     (bus_be),
    .bank_sel   (bank_sel),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_prio   (mem_prio),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_nib_en (mem_nib_en),
    .mem_rdata  (mem_rdata)
);

// File: tb/tb_pix_expander.sv
module tb_pix_expander;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [16:0] bus_ofs = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic        bank_sel = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        mem_req, mem_we, mem_prio;
    logic [16:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [3:0]  mem_nib_en;
    logic [15:0] mem_rdata = '0;

    pix_expander dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_ofs(bus_ofs), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bank_sel(bank_sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_prio(mem_prio),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_nib_en(mem_nib_en),
        .mem_rdata(mem_rdata)
    );

    // RAM model: word content is a fixed pattern of its address, one cycle latency
    function automatic logic [15:0] pat(input logic [16:0] a);
        return a[15:0] ^ 16'hC35A;
    endfunction

    always @(posedge clk)
        if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);

    // R2/R3 expectation
    function automatic logic [15:0] exp_rd(input logic [15:0] w, input logic odd);
        return odd ? {4'h0, w[7:4], 4'h0, w[3:0]} : {4'h0, w[15:12], 4'h0, w[11:8]};
    endfunction

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        bank;
        logic [16:0] ofs;
        logic [1:0]  be;
        logic [15:0] wd;
        logic        ex_req;
        logic [16:0] ex_addr;
        logic [15:0] ex_wd;
        logic [3:0]  ex_nib;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 17'h00005, 2'b00, 16'h0000, 1'b1, 17'h00002, 16'h0000, 4'h0},
        '{1'b0, 1'b1, 17'h00004, 2'b00, 16'h0000, 1'b1, 17'h00002, 16'h0000, 4'h0},
        '{1'b0, 1'b0, 17'h00004, 2'b00, 16'h0000, 1'b1, 17'h10002, 16'h0000, 4'h0},
        '{1'b0, 1'b0, 17'h1FFFF, 2'b00, 16'h0000, 1'b1, 17'h1FFFF, 16'h0000, 4'h0},
        '{1'b0, 1'b1, 17'h1FFFE, 2'b00, 16'h0000, 1'b1, 17'h0FFFF, 16'h0000, 4'h0},
        '{1'b1, 1'b1, 17'h00010, 2'b11, 16'hF7E6, 1'b1, 17'h00008, 16'h7600, 4'hC},
        '{1'b1, 1'b0, 17'h00011, 2'b11, 16'h0A0B, 1'b1, 17'h10008, 16'h00AB, 4'h3},
        '{1'b1, 1'b1, 17'h00003, 2'b01, 16'h1234, 1'b1, 17'h00001, 16'h0024, 4'h1},
        '{1'b1, 1'b0, 17'h00002, 2'b10, 16'h5C6D, 1'b1, 17'h10001, 16'hCD00, 4'h8},
        '{1'b1, 1'b1, 17'h00006, 2'b00, 16'hFFFF, 1'b0, 17'h00003, 16'h0000, 4'h0}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive_rd(input logic bank, input logic [16:0] ofs);
        bus_req = 1'b1; bus_we = 1'b0; bank_sel = bank; bus_ofs = ofs; bus_be = 2'b00;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 rd_valid in reset", 32'(rd_valid), 32'h0);
        chk(rd_data == 16'h0, "R4 rd_data in reset", 32'(rd_data), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_req = 1'b1; bus_we = VEC[i].we; bank_sel = VEC[i].bank;
            bus_ofs = VEC[i].ofs; bus_be = VEC[i].be; bus_wdata = VEC[i].wd;
            #1;
            chk(mem_req == VEC[i].ex_req, VEC[i].ex_req ? "R1 mem_req" : "R9 mem_req with be=00",
                32'(mem_req), 32'(VEC[i].ex_req));
            if (VEC[i].ex_req) begin
                chk(mem_addr == VEC[i].ex_addr, "R1 mem_addr", 32'(mem_addr), 32'(VEC[i].ex_addr));
                chk(mem_prio == VEC[i].we, "R8 mem_prio", 32'(mem_prio), 32'(VEC[i].we));
            end
            if (VEC[i].we && VEC[i].ex_req) begin
                chk(mem_wdata == VEC[i].ex_wd, "R6 R7 mem_wdata", 32'(mem_wdata), 32'(VEC[i].ex_wd));
                chk(mem_nib_en == VEC[i].ex_nib, "R6 R7 mem_nib_en", 32'(mem_nib_en), 32'(VEC[i].ex_nib));
            end
            @(negedge clk);
            bus_req = 1'b0;
            #1;
            if (!VEC[i].we) begin
                chk(rd_valid == 1'b1, "R5 rd_valid after read", 32'(rd_valid), 32'h1);
                chk(rd_data == exp_rd(pat(VEC[i].ex_addr), VEC[i].ofs[0]),
                    VEC[i].ofs[0] ? "R2 odd read" : "R3 even read",
                    32'(rd_data), 32'(exp_rd(pat(VEC[i].ex_addr), VEC[i].ofs[0])));
                chk((rd_data & 16'hF0F0) == 16'h0, "R4 pad bits", 32'(rd_data), 32'h0);
            end else begin
                chk(rd_valid == 1'b0, "R5 no rd_valid after write", 32'(rd_valid), 32'h0);
            end
        end

        // back-to-back reads with alternating lanes and banks
        @(negedge clk);
        drive_rd(1'b1, 17'h00007);
        @(negedge clk);
        drive_rd(1'b0, 17'h00006);
        #1;
        chk(rd_data == exp_rd(pat(17'h00003), 1'b1), "R2 back-to-back first",
            32'(rd_data), 32'(exp_rd(pat(17'h00003), 1'b1)));
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        chk(rd_data == exp_rd(pat(17'h10003), 1'b0), "R3 back-to-back second",
            32'(rd_data), 32'(exp_rd(pat(17'h10003), 1'b0)));
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R5 valid lasts one cycle", 32'(rd_valid), 32'h0);
        chk(rd_data == 16'h0, "R4 data zero when idle", 32'(rd_data), 32'h0);

        // reset drops a pending read
        @(negedge clk);
        drive_rd(1'b1, 17'h00009);
        rst = 1'b1;
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        chk(rd_valid == 1'b0, "R10 reset drops pending read", 32'(rd_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R10 no valid after reset release", 32'(rd_valid), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R5 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule